// File: doc/BRIEF.md
# Edge-Triggered Debug Breakpoint Request Unit

This block turns an active-low external breakpoint pin into a debug interrupt request for a processor core. When its edge-mode bit is set, the pin stops acting as a level-sensitive halt line. Instead, a high-to-low transition on it raises a single debug request. The request waits for the core's once-per-instruction sample strobe, and then the block issues a one-cycle pulse that starts the debug exception.

The pin is asynchronous to the core clock. It passes through a synchronizer of parameterised depth, and the block finds a falling edge by comparing the newest synchronized value with the one before it. A small state machine has three states: idle, request pending and in handler. Because it is in exactly one of these at a time, a request can never be pending while the handler runs, and one exception can never be nested inside another. The handler leaves the in-handler state by strobing handler-done.

Top module: `brk_edge_req`

## Requirements
- R1: While reset is asserted (rstN low) and in the first cycle after it, excStart, reqPending and inHandler are 0. Reset loads the synchronizer with the idle-high level.
- R2: With edgeModeEn = 1 and the block idle, a falling edge on brkPinN sets reqPending. The pin must be low at clock edge n, and reqPending reads 1 after edge n+2 (SYNC_STAGES = 2), not before.
- R3: A rising edge on brkPinN, or a pin held low, creates no request. This includes a pin that is already low when edgeModeEn is set.
- R4: A pending request is held until samplePoint is 1 at a clock edge. After that edge, excStart is 1 for exactly one cycle, reqPending is 0 and inHandler is 1.
- R5: Further falling edges while a request is pending merge into that request, so only one excStart pulse results.
- R6: Falling edges while inHandler is 1 are dropped. samplePoint during the handler gives no excStart, and no request remains after the handler ends.
- R7: handlerDone = 1 at a clock edge clears inHandler after that edge. When the handler is not active, handlerDone has no effect, and a pending request stays pending.
- R8: With edgeModeEn = 0, falling edges create no request. Clearing edgeModeEn drops a pending request after the next clock edge.
- R9: samplePoint with no request pending produces no excStart.
- R10: A pin that is low when reset is released counts as one falling edge, because the synchronizer starts high. reqPending rises after the third clock edge following release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brkPinN | input | 1 | Raw active-low breakpoint pin, asynchronous |
| edgeModeEn | input | 1 | Selects edge-triggered debug request mode |
| samplePoint | input | 1 | Instruction-boundary interrupt sample strobe |
| handlerDone | input | 1 | Debug handler completion strobe |
| excStart | output | 1 | One-cycle debug exception start pulse |
| reqPending | output | 1 | A debug request is waiting for a sample point |
| inHandler | output | 1 | The debug exception is being serviced |

## Verification
The assertions assume that edgeModeEn, samplePoint and handlerDone are synchronous to clk and settle before each rising edge. Only brkPinN may change at any time. They also assume that handlerDone is only meaningful while the handler runs, which the state machine enforces by ignoring it elsewhere. The stimulus changes every input a short time after a rising edge, so each value is stable when it is sampled. Outputs are read at that same point, on the cycle counted from the synchronizer depth plus the state register.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PENDING = 2'd1,
    ST_SERVICE = 2'd2
  } brkState_t;

  typedef struct packed {
    logic fallEdge;
  } pinEvt_t;

endpackage

// File: rtl/brk_pin_datapath.sv
module brk_pin_datapath #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brkPinN,
  output brk_pkg::pinEvt_t pinEvt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stageQ;
  logic                   prevQ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b1;
        else       stageQ[g] <= brkPinN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= 1'b1;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= stageQ[LAST];
  end

  always_comb begin
    pinEvt.fallEdge = prevQ & ~stageQ[LAST];
  end

  // R2: a detected fall needs a high-to-low change, so two in a row cannot occur
  a_r2_no_double_fall: assert property (@(posedge clk) disable iff (!rstN)
    pinEvt.fallEdge |=> !pinEvt.fallEdge);

endmodule

// File: rtl/brk_req_control.sv
module brk_req_control (
  input  logic             clk,
  input  logic             rstN,
  input  brk_pkg::pinEvt_t pinEvt,
  input  logic             edgeModeEn,
  input  logic             samplePoint,
  input  logic             handlerDone,
  output logic             excStart,
  output logic             reqPending,
  output logic             inHandler
);
  import brk_pkg::*;

  brkState_t stateQ, stateD;
  logic      takeReq;

  always_comb begin
    takeReq = (stateQ == ST_PENDING) && edgeModeEn && samplePoint;
    stateD  = stateQ;
    case (stateQ)
      ST_IDLE:    if (edgeModeEn && pinEvt.fallEdge) stateD = ST_PENDING;
      ST_PENDING: if (!edgeModeEn)                   stateD = ST_IDLE;
                  else if (samplePoint)              stateD = ST_SERVICE;
      ST_SERVICE: if (handlerDone)                   stateD = ST_IDLE;
      default:                                       stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      excStart <= 1'b0;
    end else begin
      stateQ   <= stateD;
      excStart <= takeReq;
    end
  end

  assign reqPending = (stateQ == ST_PENDING);
  assign inHandler  = (stateQ == ST_SERVICE);

  // R2: a request only appears after a detected fall in edge mode
  a_r2_pend_from_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqPending) |-> $past(pinEvt.fallEdge) && $past(edgeModeEn));

  // R4: the start pulse follows a pending request met by a sample point
  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    excStart |-> $past(reqPending) && $past(samplePoint) && inHandler);

  // R4: the start pulse lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    excStart |=> !excStart);

  // R6: no new exception while the handler runs
  a_r6_no_nest: assert property (@(posedge clk) disable iff (!rstN)
    (inHandler && !handlerDone) |=> (inHandler && !excStart && !reqPending));

  // R7: handler completion releases the in-handler flag
  a_r7_done_release: assert property (@(posedge clk) disable iff (!rstN)
    (inHandler && handlerDone) |=> !inHandler);

  // R8: leaving edge mode leaves nothing pending
  a_r8_mode_off_clear: assert property (@(posedge clk) disable iff (!rstN)
    !edgeModeEn |=> !reqPending);

  // R9: a sample point without a request starts nothing
  a_r9_idle_sample: assert property (@(posedge clk) disable iff (!rstN)
    (samplePoint && !reqPending) |=> !excStart);

endmodule

// File: rtl/brk_edge_req.sv
module brk_edge_req #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic brkPinN,
  input  logic edgeModeEn,
  input  logic samplePoint,
  input  logic handlerDone,
  output logic excStart,
  output logic reqPending,
  output logic inHandler
);
  brk_pkg::pinEvt_t pinEvt;

  brk_pin_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .brkPinN (brkPinN),
    .pinEvt  (pinEvt)
  );

  brk_req_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .pinEvt      (pinEvt),
    .edgeModeEn  (edgeModeEn),
    .samplePoint (samplePoint),
    .handlerDone (handlerDone),
    .excStart    (excStart),
    .reqPending  (reqPending),
    .inHandler   (inHandler)
  );

  // R1: outputs quiet while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!excStart && !reqPending && !inHandler);
    end
  end

endmodule

// File: tb/test_brk_edge_req.sv
`timescale 1ns/1ps
module test_brk_edge_req;
  logic clk = 1'b0;
  logic rstN, brkPinN, edgeModeEn, samplePoint, handlerDone;
  logic excStart, reqPending, inHandler;
  int   vecCount = 0;
  int   errCount = 0;
  bit   doneFlag = 1'b0;

  always #4 clk = ~clk;

  brk_edge_req i_brk_edge_req (
    .clk(clk), .rstN(rstN), .brkPinN(brkPinN), .edgeModeEn(edgeModeEn),
    .samplePoint(samplePoint), .handlerDone(handlerDone),
    .excStart(excStart), .reqPending(reqPending), .inHandler(inHandler)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; brkPinN = 1'b1; edgeModeEn = 1'b1;
    samplePoint = 1'b0; handlerDone = 1'b0;
    tick(3);
    check("R1", "excStart in reset", excStart, 1'b0);
    check("R1", "reqPending in reset", reqPending, 1'b0);
    check("R1", "inHandler in reset", inHandler, 1'b0);
    rstN = 1'b1;
    tick(1);
    check("R1", "reqPending after reset", reqPending, 1'b0);
    check("R1", "inHandler after reset", inHandler, 1'b0);
    tick(3);
    check("R1", "idle-high pin gives no request", reqPending, 1'b0);
  endtask

  task automatic t_basic();
    brkPinN = 1'b0;
    tick(2);
    check("R2", "pending not yet after 2 edges", reqPending, 1'b0);
    tick(1);
    check("R2", "pending after 3 edges", reqPending, 1'b1);
    tick(4);
    check("R4", "pending held without sample", reqPending, 1'b1);
    check("R4", "no start without sample", excStart, 1'b0);
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R4", "start pulse", excStart, 1'b1);
    check("R4", "pending cleared", reqPending, 1'b0);
    check("R4", "inHandler set", inHandler, 1'b1);
    tick(1);
    check("R4", "pulse one cycle", excStart, 1'b0);
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    check("R7", "done clears inHandler", inHandler, 1'b0);
    brkPinN = 1'b1;
    tick(4);
    check("R3", "rising edge ignored", reqPending, 1'b0);
  endtask

  task automatic t_steady_low();
    edgeModeEn = 1'b0;
    brkPinN = 1'b0;
    tick(4);
    check("R8", "fall with mode off", reqPending, 1'b0);
    edgeModeEn = 1'b1;
    tick(5);
    check("R3", "steady low after mode on", reqPending, 1'b0);
    brkPinN = 1'b1;
    tick(4);
    check("R3", "rise with mode on", reqPending, 1'b0);
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R9", "sample with nothing pending", excStart, 1'b0);
    check("R9", "no handler entry", inHandler, 1'b0);
  endtask

  task automatic t_merge();
    brkPinN = 1'b0;
    tick(3);
    check("R5", "first request pending", reqPending, 1'b1);
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    check("R7", "done while idle keeps pending", reqPending, 1'b1);
    check("R7", "done while idle no handler", inHandler, 1'b0);
    brkPinN = 1'b1;
    tick(3);
    brkPinN = 1'b0;
    tick(4);
    check("R5", "still single pending", reqPending, 1'b1);
    samplePoint = 1'b1;
    tick(1);
    check("R5", "one start", excStart, 1'b1);
    tick(1);
    samplePoint = 1'b0;
    check("R5", "no second start", excStart, 1'b0);
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    tick(2);
    check("R5", "nothing left pending", reqPending, 1'b0);
    brkPinN = 1'b1;
    tick(4);
  endtask

  task automatic t_nest();
    brkPinN = 1'b0;
    tick(3);
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R6", "handler entered", inHandler, 1'b1);
    brkPinN = 1'b1;
    tick(3);
    brkPinN = 1'b0;
    tick(4);
    check("R6", "edge in handler not pending", reqPending, 1'b0);
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R6", "no nested start", excStart, 1'b0);
    check("R6", "still in handler", inHandler, 1'b1);
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    check("R7", "handler ended", inHandler, 1'b0);
    tick(2);
    check("R6", "dropped edge not revived", reqPending, 1'b0);
    brkPinN = 1'b1;
    tick(4);
  endtask

  task automatic t_mode_drop();
    brkPinN = 1'b0;
    tick(3);
    check("R8", "pending before mode off", reqPending, 1'b1);
    edgeModeEn = 1'b0;
    tick(1);
    check("R8", "pending dropped", reqPending, 1'b0);
    edgeModeEn = 1'b1;
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R8", "no start after drop", excStart, 1'b0);
    brkPinN = 1'b1;
    tick(4);
  endtask

  task automatic t_reset_low();
    rstN = 1'b0;
    brkPinN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(2);
    check("R10", "not yet pending", reqPending, 1'b0);
    tick(1);
    check("R10", "low pin at release requests", reqPending, 1'b1);
    samplePoint = 1'b1;
    tick(1);
    samplePoint = 1'b0;
    check("R10", "start from release edge", excStart, 1'b1);
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    brkPinN = 1'b1;
    tick(4);
  endtask

  task automatic finish_run();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    vecCount++;
    errCount++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_steady_low();
    t_merge();
    t_nest();
    t_mode_drop();
    t_reset_low();
    finish_run();
  end

endmodule